// File: doc/BRIEF.md
# Programmable Parallel Ports with Strobe Handshake

This block gives a processor bus two 8-bit parallel ports, A and B, and one 6-bit port, C. A bus decoder supplies a register select together with single-cycle read and write strobes. One command register sets the direction of ports A and B, the function of port C and the two interrupt enables. That register can only be written. A read at the same select returns a status byte with the handshake flags, the enables and an external timer flag.

Port C can serve as a plain input, as a plain output, or as handshake lines. In handshake mode, each of ports A and B takes three port C pins: an interrupt output, a buffer-full output and an active-low strobe input. A port in input mode then becomes a strobed input, which captures its pins when the strobe falls. A port in output mode signals new data to the peripheral and waits for an acknowledge on the strobe. Port reads go through a per-bit selector. It returns the output latch, the live pins, or the captured value, depending on the port mode. All state is clocked, and reset is synchronous and active high.

Top module: `handshake_port_unit`

## Requirements
- R1: Synchronous reset clears the command register, all port latches, the handshake flags and read data, so every output enable is 0 and the status byte reads 0x40 when the timer flag is 1.
- R2: Command bit 0 set makes all eight port A enables 1, and clear makes them 0. Command bit 1 does the same for port B.
- R3: Command bits 3:2 select the port C function. 00 makes all six pins inputs. 11 makes all six pins outputs driven from the port C latch. 01 gives handshake to port A only and leaves pins 5:3 as latch outputs. 10 gives handshake to both ports.
- R4: In handshake, pin 0 is the port A interrupt output, pin 1 is the port A buffer-full output and pin 2 is the port A strobe input. Pins 3, 4 and 5 play the same roles for port B. Strobe pins always have their enable at 0.
- R5: Every command write re-initialises the handshake flags of each port. Buffer-full goes to 0. Interrupt goes to 1 only for a port that has handshake and is set as output, and to 0 otherwise.
- R6: Reading a port set as output (select 1 for A, 2 for B) returns its output latch, whatever its pins carry.
- R7: Reading a port set as input returns its live pins when that port has no handshake, and the value captured at the last strobe when it has.
- R8: In strobed input mode, a falling strobe captures the pins and sets buffer-full. A rising strobe sets interrupt only when that port's enable is on (command bit 4 for A, bit 5 for B). A read of the port clears both flags.
- R9: In strobed output mode, a write to the port sets buffer-full and clears interrupt. A falling strobe clears buffer-full, and a rising strobe sets interrupt when that port's enable is on.
- R10: A read at select 0 returns status bits in this order: bit 0 A interrupt, bit 1 A buffer-full, bit 2 A enable, bit 3 B interrupt, bit 4 B buffer-full, bit 5 B enable, bit 6 the timer flag input, and bit 7 zero.
- R11: Read data is registered. It is valid from the clock edge that samples the read strobe. A port C read (select 3) returns, per pin, the driven value for output pins and the pin input for input pins.
- R12: Selects 4 to 7 are timer slots outside this block. Writes to them change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 3 | Register select from the bus decoder |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| timer_flag | input | 1 | Timer flag reported in status |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A pin drive values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B pin drive values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 6 | Port C pin inputs (strobes are active low) |
| pc_out | output | 6 | Port C pin drive values |
| pc_oe | output | 6 | Port C output enables |

## Verification
The bench targets the difference between the captured value and the live pins. It changes the pins after a strobe capture, so a design that reads the pins in strobed mode returns the wrong byte. It strobes a port whose interrupt enable is off, which catches a design that sets interrupt without looking at the enable. It re-enters handshake in output mode to check that interrupt starts at 1, since a design that skips the initialisation would leave it at 0. It also reads back an output port while its pins carry other data, and it reads the status address after command writes, which shows whether the command value leaks onto the bus.

// File: rtl/hpu_pkg.sv
package hpu_pkg;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_PA   = 3'd1;
  localparam logic [2:0] SEL_PB   = 3'd2;
  localparam logic [2:0] SEL_PC   = 3'd3;

  typedef enum logic [1:0] {
    PC_ALL_IN  = 2'b00,
    PC_HS_A    = 2'b01,
    PC_HS_AB   = 2'b10,
    PC_ALL_OUT = 2'b11
  } pc_mode_e;

  typedef struct packed {
    logic [1:0] tmode;
    logic       ie_b;
    logic       ie_a;
    pc_mode_e   pc_mode;
    logic       dir_b;
    logic       dir_a;
  } cmd_t;

  function automatic logic hs_owned(pc_mode_e m, int idx);
    if (idx == 0) return (m == PC_HS_A) || (m == PC_HS_AB);
    return (m == PC_HS_AB);
  endfunction

endpackage

// File: rtl/hpu_stb_sync.sv
module hpu_stb_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-2:0], pin_n};
  end

  assign fall = sh_q[STAGES-1] & ~sh_q[STAGES-2];
  assign rise = ~sh_q[STAGES-1] & sh_q[STAGES-2];
endmodule

// File: rtl/hpu_port.sv
module hpu_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         is_out,
  input  logic         hs_on,
  input  logic         ie,
  input  logic         init,
  input  logic         init_intr,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  input  logic         stb_fall,
  input  logic         stb_rise,
  output logic [W-1:0] out_q,
  output logic [W-1:0] rd_val,
  output logic         bf,
  output logic         intr
);
  logic [W-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      cap_q <= '0;
      bf    <= 1'b0;
      intr  <= 1'b0;
    end else begin
      if (wr_en) out_q <= wdata;
      if (init) begin
        bf   <= 1'b0;
        intr <= init_intr;
      end else if (hs_on) begin
        if (is_out) begin
          if (wr_en) begin
            bf   <= 1'b1;
            intr <= 1'b0;
          end
          if (stb_fall) bf <= 1'b0;
        end else begin
          if (rd_en) begin
            bf   <= 1'b0;
            intr <= 1'b0;
          end
          if (stb_fall) begin
            bf    <= 1'b1;
            cap_q <= pin_in;
          end
        end
        if (stb_rise && ie) intr <= 1'b1;
      end
    end
  end

  always_comb begin
    if (is_out)     rd_val = out_q;
    else if (hs_on) rd_val = cap_q;
    else            rd_val = pin_in;
  end
endmodule

// File: rtl/handshake_port_unit.sv
module handshake_port_unit #(
  parameter int PW  = 8,
  parameter int CW  = 6,
  parameter int SW  = 3,
  parameter int SYN = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] sel,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rdata,
  input  logic          timer_flag,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic [PW-1:0] pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic [PW-1:0] pb_oe,
  input  logic [CW-1:0] pc_in,
  output logic [CW-1:0] pc_out,
  output logic [CW-1:0] pc_oe
);
  import hpu_pkg::*;

  localparam int NP   = 2;
  localparam int HS_W = CW / NP;

  cmd_t          cmd_q, cmd_new;
  logic [CW-1:0] pc_q;
  logic [PW-1:0] rdata_q;
  logic          cmd_wr;

  logic [PW-1:0] pin_in [NP];
  logic [PW-1:0] out_q  [NP];
  logic [PW-1:0] rd_val [NP];
  logic [NP-1:0] dir, dir_new, ie, hs_on, hs_new, bf, intr, stb_fall, stb_rise;

  assign cmd_new = cmd_t'(wdata[7:0]);
  assign cmd_wr  = wr_stb && (sel == SW'(SEL_CTRL));

  assign pin_in[0] = pa_in;
  assign pin_in[1] = pb_in;
  assign dir       = {cmd_q.dir_b, cmd_q.dir_a};
  assign dir_new   = {cmd_new.dir_b, cmd_new.dir_a};
  assign ie        = {cmd_q.ie_b, cmd_q.ie_a};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      pc_q  <= '0;
    end else begin
      if (cmd_wr) cmd_q <= cmd_new;
      if (wr_stb && sel == SW'(SEL_PC)) pc_q <= wdata[CW-1:0];
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_port
    assign hs_on[g]  = hs_owned(cmd_q.pc_mode, g);
    assign hs_new[g] = hs_owned(cmd_new.pc_mode, g);

    hpu_stb_sync #(.STAGES(SYN)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .pin_n (pc_in[g*HS_W+2]),
      .fall  (stb_fall[g]),
      .rise  (stb_rise[g])
    );

    hpu_port #(.W(PW)) u_port (
      .clk       (clk),
      .rst       (rst),
      .is_out    (dir[g]),
      .hs_on     (hs_on[g]),
      .ie        (ie[g]),
      .init      (cmd_wr),
      .init_intr (hs_new[g] & dir_new[g]),
      .wr_en     (wr_stb && sel == SW'(SEL_PA) + SW'(g)),
      .rd_en     (rd_stb && sel == SW'(SEL_PA) + SW'(g)),
      .wdata     (wdata),
      .pin_in    (pin_in[g]),
      .stb_fall  (stb_fall[g]),
      .stb_rise  (stb_rise[g]),
      .out_q     (out_q[g]),
      .rd_val    (rd_val[g]),
      .bf        (bf[g]),
      .intr      (intr[g])
    );
  end

  assign pa_out = out_q[0];
  assign pb_out = out_q[1];
  assign pa_oe  = {PW{dir[0]}};
  assign pb_oe  = {PW{dir[1]}};

  always_comb begin
    pc_oe  = (cmd_q.pc_mode == PC_ALL_IN) ? '0 : '1;
    pc_out = pc_q;
    for (int g = 0; g < NP; g++) begin
      if (hs_on[g]) begin
        pc_out[g*HS_W]   = intr[g];
        pc_out[g*HS_W+1] = bf[g];
        pc_oe[g*HS_W+2]  = 1'b0;
      end
    end
  end

  logic [CW-1:0] pc_view;
  logic [7:0]    status;
  assign pc_view = (pc_oe & pc_out) | (~pc_oe & pc_in);
  assign status  = {1'b0, timer_flag, cmd_q.ie_b, bf[1], intr[1],
                    cmd_q.ie_a, bf[0], intr[0]};

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd_stb) begin
      case (sel)
        SW'(SEL_CTRL): rdata_q <= PW'(status);
        SW'(SEL_PA):   rdata_q <= rd_val[0];
        SW'(SEL_PB):   rdata_q <= rd_val[1];
        SW'(SEL_PC):   rdata_q <= PW'(pc_view);
        default:       rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/hpu_checker.sv
module hpu_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] sel,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic [7:0] rdata,
  input logic       timer_flag,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_oe,
  input logic [5:0] pc_out,
  input logic [5:0] pc_oe,
  input logic [1:0] mode,
  input logic       dir_a,
  input logic       a_edge
);
  logic a_hs;
  assign a_hs = (mode == 2'b01) || (mode == 2'b10);

  // R1
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 6'h00 && pa_out == 8'h00));

  // R2
  p_oe_uniform_r2: assert property (@(posedge clk) disable iff (rst)
    (pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF));

  // R4
  p_stb_is_input_r4: assert property (@(posedge clk) disable iff (rst)
    a_hs |-> !pc_oe[2]);

  // R6
  p_readback_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && sel == 3'd1 && dir_a) |=> rdata == $past(pa_out));

  // R8
  p_rd_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && sel == 3'd1 && !dir_a && a_hs && !a_edge) |=> (!pc_out[0] && !pc_out[1]));

  // R9
  p_wr_sets_bf_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && sel == 3'd1 && dir_a && a_hs && !a_edge) |=> (pc_out[1] && !pc_out[0]));

  // R10
  p_status_timer_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && sel == 3'd0) |=> rdata[6] == $past(timer_flag));

  // R12
  p_timer_slot_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && sel[2]) |=> rdata == 8'h00);
endmodule

bind handshake_port_unit hpu_checker u_hpu_checker (
  .clk        (clk),
  .rst        (rst),
  .sel        (sel),
  .rd_stb     (rd_stb),
  .wr_stb     (wr_stb),
  .rdata      (rdata),
  .timer_flag (timer_flag),
  .pa_out     (pa_out),
  .pa_oe      (pa_oe),
  .pb_oe      (pb_oe),
  .pc_out     (pc_out),
  .pc_oe      (pc_oe),
  .mode       (cmd_q.pc_mode),
  .dir_a      (cmd_q.dir_a),
  .a_edge     (stb_fall[0] | stb_rise[0])
);

// File: tb/handshake_port_unit_tb_top.sv
module handshake_port_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NV         = 17;

  // {req[3:0], is_rd, sel[2:0], data[7:0]}
  localparam logic [15:0] VEC [NV] = '{
    {4'd2,  1'b0, 3'd0, 8'h03},  // R2 A,B outputs, C input
    {4'd6,  1'b0, 3'd1, 8'h11},  // R6
    {4'd6,  1'b0, 3'd2, 8'h22},  // R6
    {4'd6,  1'b1, 3'd1, 8'h11},  // R6 readback A
    {4'd6,  1'b1, 3'd2, 8'h22},  // R6 readback B
    {4'd10, 1'b1, 3'd0, 8'h40},  // R10 status, command hidden
    {4'd7,  1'b0, 3'd0, 8'h00},  // R7 all inputs
    {4'd7,  1'b1, 3'd1, 8'h5A},  // R7 live pins A
    {4'd7,  1'b1, 3'd2, 8'hC3},  // R7 live pins B
    {4'd11, 1'b1, 3'd3, 8'h24},  // R11 C input view
    {4'd3,  1'b0, 3'd3, 8'h15},  // R3 C latch
    {4'd3,  1'b0, 3'd0, 8'h0C},  // R3 C all output
    {4'd3,  1'b1, 3'd3, 8'h15},  // R3 C output view
    {4'd12, 1'b0, 3'd4, 8'hFF},  // R12 timer slot write
    {4'd12, 1'b1, 3'd4, 8'h00},  // R12 timer slot read
    {4'd10, 1'b1, 3'd0, 8'h40},  // R10 status unchanged by slot 4
    {4'd12, 1'b1, 3'd5, 8'h00}   // R12
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel = '0;
  logic       rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       timer_flag = 1'b1;
  logic [7:0] pa_in = 8'h5A, pb_in = 8'hC3;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe;
  logic [5:0] pc_in = 6'h24;
  logic [5:0] pc_out, pc_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  handshake_port_unit dut_i (
    .clk(clk), .rst(rst), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata(wdata), .rdata(rdata), .timer_flag(timer_flag),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    sel = s; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk);
    sel = s; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    d = rdata;
  endtask

  task automatic stb(input int grp, input logic lvl);
    @(negedge clk);
    pc_in[grp*3+2] = lvl;
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pc_oe", {2'b0, pc_oe}, 8'h00);
    chk("R1 rdata", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][11]) begin
        rd(VEC[i][10:8], d);
        chk($sformatf("R%0d vec%0d", VEC[i][15:12], i), d, VEC[i][7:0]);
      end else begin
        wr(VEC[i][10:8], VEC[i][7:0]);
      end
    end

    // R2 direction bits
    wr(3'd0, 8'h01);
    chk("R2 pa_oe", pa_oe, 8'hFF);
    chk("R2 pb_oe", pb_oe, 8'h00);
    chk("R6 pa_out latch", pa_out, 8'h11);

    // R3 / R4 handshake on A only
    wr(3'd0, 8'h04);
    chk("R4 pc_oe mode01", {2'b0, pc_oe}, 8'h3B);
    chk("R3 pc_out upper latch", {5'b0, pc_out[5:3]}, 8'h02);
    chk("R5 A flags input", {6'b0, pc_out[1:0]}, 8'h00);

    // R4 both ports handshake
    wr(3'd0, 8'h08);
    chk("R4 pc_oe mode10", {2'b0, pc_oe}, 8'h1B);

    // R8 strobed input on A with enable
    wr(3'd0, 8'h18);
    chk("R5 flags after entry", {4'b0, pc_out[4:3], pc_out[1:0]}, 8'h00);
    pa_in = 8'h77;
    stb(0, 1'b0);
    chk("R8 A bf on fall", {7'b0, pc_out[1]}, 8'h01);
    chk("R8 A intr waits rise", {7'b0, pc_out[0]}, 8'h00);
    pa_in = 8'h99;
    stb(0, 1'b1);
    chk("R8 A intr on rise", {7'b0, pc_out[0]}, 8'h01);
    rd(3'd0, d);
    chk("R10 status flags", d, 8'h47);
    rd(3'd1, d);
    chk("R7 captured value", d, 8'h77);
    chk("R8 read clears flags", {6'b0, pc_out[1:0]}, 8'h00);

    // R8 port B with enable off
    pb_in = 8'h3C;
    stb(1, 1'b0);
    chk("R8 B bf on fall", {7'b0, pc_out[4]}, 8'h01);
    pb_in = 8'h00;
    stb(1, 1'b1);
    chk("R8 B intr masked", {7'b0, pc_out[3]}, 8'h00);
    rd(3'd2, d);
    chk("R7 B captured", d, 8'h3C);
    chk("R8 B read clears bf", {7'b0, pc_out[4]}, 8'h00);

    // R9 strobed output on A
    wr(3'd0, 8'h19);
    chk("R5 A out entry intr", {6'b0, pc_out[1:0]}, 8'h01);
    wr(3'd1, 8'hA5);
    chk("R6 pa_out", pa_out, 8'hA5);
    chk("R9 write flags", {6'b0, pc_out[1:0]}, 8'h02);
    stb(0, 1'b0);
    chk("R9 ack clears bf", {7'b0, pc_out[1]}, 8'h00);
    stb(0, 1'b1);
    chk("R9 rise sets intr", {7'b0, pc_out[0]}, 8'h01);

    // R5 leaving handshake clears flags
    wr(3'd0, 8'h00);
    rd(3'd0, d);
    chk("R5 status after exit", d, 8'h40);
    timer_flag = 1'b0;
    rd(3'd0, d);
    chk("R10 timer flag low", d, 8'h00);

    // R1 reset in mid-run
    wr(3'd0, 8'h03);
    wr(3'd1, 8'hEE);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pa_oe after reset", pa_oe, 8'h00);
    chk("R1 pa_out after reset", pa_out, 8'h00);
    timer_flag = 1'b1;
    rd(3'd0, d);
    chk("R1 status after reset", d, 8'h40);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule